// File: doc/BRIEF.md
# SMBus master command controller

This block is a byte-oriented master for a two-wire SMBus/I2C bus. A host drives it through a small register window. The window has a data register, a write-only control register and a read-only status register. The host starts and ends transfers with two command bits. The block reads those bits against its current mode, which is one of idle/listening, master-transmitting or master-receiving. From that it produces a START followed by an address, a repeated START, a STOP, or a STOP immediately followed by a new START, so the bus changes transactions without being released.

Bytes move MSB first. Each byte is followed by a ninth acknowledge clock. An active-low pending flag tells the host that a byte has completed and the block needs service. Accessing the data register clears that flag and also starts the next byte. A write starts it in transmit mode and a read starts it in receive mode. The bus lines are open-drain. The block drives only pull-low enables and reads back the wire levels. SCL runs at a fixed fraction of the system clock.

For a repeated START, or for a chained STOP+START, the bus conditions are produced first. The block then holds SCL low until the host writes the new address to the data register.

Top module: `smb_master_ctl`

## Requirements
- R1: After reset, the pending flag reads 1 and the mode is idle/listening. Both line enables are 0 and int_n is 1.
- R2: Start command in idle mode: a START (SDA falls with SCL high) is sent, followed by the data register as the address byte. After the ninth clock, the mode is master-transmit if address bit 0 is 0 and master-receive if it is 1.
- R3: Start command in either master mode: a repeated START is sent with no STOP before it. SCL is then held low. The next data write is sent as an address, and its bit 0 selects the resulting mode as in R2.
- R4: Stop command in either master mode: a STOP (SDA rises with SCL high) is sent and the mode returns to idle. Both line enables end at 0.
- R5: Start and stop commands set together in a master mode: a STOP and then a START are sent. SCL is then held low and the block waits for the address write.
- R6: Every other command combination does nothing. This covers stop alone in idle, start plus stop in idle, and neither bit set in any mode. No bus condition appears and the status is unchanged.
- R7: On the ninth clock of each received byte, SDA is pulled low when the acknowledge-enable bit is 1 and left high when it is 0.
- R8: The pending flag drops to 0 at the end of every byte, whether address, transmitted or received.
- R9: A data write in master-transmit mode sets the pending flag to 1 and sends the byte MSB first. A data read in master-receive mode sets it to 1 and clocks in the next byte. The following data read returns that byte.
- R10: int_n is 0 exactly when the interrupt-enable bit is 1 and the pending flag is 0.
- R11: Status bit 0 holds the SDA level sampled on the ninth clock of the last transmitted byte (0 = acknowledged).
- R12: Register map. host_sel=0 selects the data register. host_sel=1 writes control and reads status. Control bits: bit6 start, bit5 stop, bit1 acknowledge enable, bit0 interrupt enable. Status bits: bit7 pending flag, bit6 busy, bit5 master, bit4 receiving, bit0 acknowledge sample; the other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | 0 = data register, 1 = control (write) / status (read) |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Selected register contents |
| int_n | output | 1 | Active-low interrupt |
| scl_in | input | 1 | Level of the SCL wire |
| sda_in | input | 1 | Level of the SDA wire |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench attaches a behavioural slave that logs STARTs, STOPs, written bytes and the master's acknowledges. It targets the command table's mode dependence. Stop or start+stop issued while idle must leave the bus silent; a decoder that ignored the mode would emit a spurious STOP. The chained and repeated-START cases check that no STOP slips in before a repeated START, and that SCL stays low afterwards; a controller that released the bus would let SCL float high there. The receive path checks that the acknowledge-enable bit turns into a NACK on the last byte, so the slave stops sending; a fixed acknowledge would make the slave keep driving data. The bench also checks that a data-register access is what re-arms the pending flag; a design that cleared it on a status read would leave int_n stuck low. A non-existent address must set the status acknowledge bit.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam int BYTE_BITS = 8;

    // control register bit positions
    localparam int CTL_IEN = 0;
    localparam int CTL_ACK = 1;
    localparam int CTL_STO = 5;
    localparam int CTL_STA = 6;

    // status register bit positions
    localparam int STS_LAK  = 0;
    localparam int STS_RCV  = 4;
    localparam int STS_MST  = 5;
    localparam int STS_BUSY = 6;
    localparam int STS_PEND = 7;

    typedef enum logic [1:0] {
        MODE_SRX = 2'd0,
        MODE_MTX = 2'd1,
        MODE_MRX = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        CMD_NOP    = 3'd0,
        CMD_START  = 3'd1,
        CMD_RSTART = 3'd2,
        CMD_STOP   = 3'd3,
        CMD_CHAIN  = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        OP_START_TX = 3'd0,
        OP_RSTART   = 3'd1,
        OP_STOP     = 3'd2,
        OP_CHAIN    = 3'd3,
        OP_TX       = 3'd4,
        OP_RX       = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        E_IDLE  = 3'd0,
        E_HOLD  = 3'd1,
        E_START = 3'd2,
        E_STOP  = 3'd3,
        E_BIT   = 3'd4
    } est_e;

    typedef struct packed {
        est_e                 st;
        logic [1:0]           ph;
        logic [3:0]           bitn;
        logic [BYTE_BITS-1:0] sh;
        logic                 rx;
        logic                 then_byte;
        logic                 then_start;
        logic                 ackd;
        logic                 scl;
        logic                 sda;
        logic                 done;
        logic                 aks;
    } eng_s;

    typedef struct packed {
        mode_e                mode;
        logic                 pend;
        logic                 ien;
        logic                 acken;
        logic [BYTE_BITS-1:0] data;
        logic                 addr_ph;
        cmd_e                 cmd_pend;
        logic                 tx_pend;
        logic                 rx_pend;
        logic                 lak;
    } top_s;

endpackage

// File: rtl/smb_cmd_decode.sv
module smb_cmd_decode
    import smb_pkg::*;
(
    input  mode_e mode,
    input  logic  sta,
    input  logic  sto,
    output cmd_e  cmd
);
    always_comb begin
        cmd = CMD_NOP;
        if (mode == MODE_SRX) begin
            if (sta && !sto) cmd = CMD_START;
        end else begin
            unique case ({sta, sto})
                2'b10:   cmd = CMD_RSTART;
                2'b01:   cmd = CMD_STOP;
                2'b11:   cmd = CMD_CHAIN;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/smb_tick.sv
module smb_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == CW'(DIV - 1));

    always_comb begin
        if (!run)      cnt_d = '0;
        else if (tick) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/smb_byte_engine.sv
module smb_byte_engine
    import smb_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  op_e                  op_i,
    input  logic [BYTE_BITS-1:0] tx_byte_i,
    input  logic                 ack_en_i,
    input  logic                 scl_in,
    input  logic                 sda_in,
    output logic                 scl_oe,
    output logic                 sda_oe,
    output logic                 busy,
    output logic                 done,
    output logic [BYTE_BITS-1:0] rx_byte,
    output logic                 ack_smp
);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_BITS);

    localparam eng_s ENG_RST = '{
        st: E_IDLE, ph: 2'd0, bitn: 4'd0, sh: '0, rx: 1'b0,
        then_byte: 1'b0, then_start: 1'b0, ackd: 1'b0,
        scl: 1'b0, sda: 1'b0, done: 1'b0, aks: 1'b0
    };

    eng_s q, d;
    logic tick;

    assign busy    = (q.st == E_START) || (q.st == E_STOP) || (q.st == E_BIT);
    assign scl_oe  = q.scl;
    assign sda_oe  = q.sda;
    assign done    = q.done;
    assign rx_byte = q.sh;
    assign ack_smp = q.aks;

    smb_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .tick (tick)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            E_IDLE, E_HOLD: begin
                if (start_i) begin
                    d.ph         = 2'd0;
                    d.bitn       = 4'd0;
                    d.rx         = 1'b0;
                    d.then_byte  = 1'b0;
                    d.then_start = 1'b0;
                    d.sh         = tx_byte_i;
                    d.ackd       = ack_en_i;
                    unique case (op_i)
                        OP_START_TX: begin d.st = E_START; d.then_byte = 1'b1; end
                        OP_RSTART:   d.st = E_START;
                        OP_STOP:     d.st = E_STOP;
                        OP_CHAIN:    begin d.st = E_STOP; d.then_start = 1'b1; end
                        OP_TX:       d.st = E_BIT;
                        default:     begin d.st = E_BIT; d.rx = 1'b1; end
                    endcase
                end
            end
            E_START: begin
                if (tick) begin
                    unique case (q.ph)
                        2'd0: d.sda = 1'b0;   // release SDA while SCL is low or idle
                        2'd1: d.scl = 1'b0;   // let SCL rise
                        2'd2: d.sda = 1'b1;   // SDA falls with SCL high
                        default: d.scl = 1'b1;
                    endcase
                    d.ph = q.ph + 2'd1;
                    if (q.ph == 2'd3) d.st = q.then_byte ? E_BIT : E_HOLD;
                end
            end
            E_STOP: begin
                if (tick) begin
                    unique case (q.ph)
                        2'd0: begin d.scl = 1'b1; d.sda = 1'b1; end
                        2'd1: d.scl = 1'b0;
                        2'd2: d.sda = 1'b0;   // SDA rises with SCL high
                        default: ;
                    endcase
                    d.ph = q.ph + 2'd1;
                    if (q.ph == 2'd3) begin
                        d.st         = q.then_start ? E_START : E_IDLE;
                        d.then_start = 1'b0;
                    end
                end
            end
            E_BIT: begin
                if (tick) begin
                    unique case (q.ph)
                        2'd0: begin
                            if (q.bitn < LAST_BIT) d.sda = q.rx ? 1'b0 : ~q.sh[BYTE_BITS-1];
                            else                   d.sda = q.rx ? q.ackd : 1'b0;
                        end
                        2'd1: d.scl = 1'b0;
                        2'd2: begin
                            if (q.bitn < LAST_BIT) d.sh = {q.sh[BYTE_BITS-2:0], sda_in};
                            else if (!q.rx)        d.aks = sda_in;
                        end
                        default: begin
                            d.scl = 1'b1;
                            if (q.bitn == LAST_BIT) begin
                                d.st   = E_HOLD;
                                d.done = 1'b1;
                                d.bitn = 4'd0;
                            end else begin
                                d.bitn = q.bitn + 4'd1;
                            end
                        end
                    endcase
                    d.ph = q.ph + 2'd1;
                end
            end
            default: d = ENG_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= ENG_RST;
        else        q <= d;
    end

    // data moves only while SCL is held low (R9)
    p_sda_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == E_BIT && $past(q.st) == E_BIT && !q.scl && !$past(q.scl))
            |-> $stable(q.sda));

    // an idle engine has let go of both wires (R4)
    p_idle_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == E_IDLE) |-> (!scl_oe && !sda_oe));

    // engine goes busy the cycle after it is handed an operation (R9)
    p_launch_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy) |=> busy);

    // SCL stays pulled low while waiting for the host (R5)
    p_hold_scl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == E_HOLD) |-> scl_oe);

endmodule

// File: rtl/smb_master_ctl.sv
module smb_master_ctl
    import smb_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_sel,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       int_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe
);
    localparam top_s TOP_RST = '{
        mode: MODE_SRX, pend: 1'b1, ien: 1'b0, acken: 1'b0, data: '0,
        addr_ph: 1'b0, cmd_pend: CMD_NOP, tx_pend: 1'b0, rx_pend: 1'b0, lak: 1'b0
    };

    top_s q, d;
    cmd_e dec_cmd;
    logic launch;
    op_e  launch_op;
    logic eng_busy, eng_done, eng_ack;
    logic [BYTE_BITS-1:0] eng_rx;
    logic busy_any;
    logic [7:0] status;

    smb_cmd_decode u_dec (
        .mode(q.mode),
        .sta (host_wdata[CTL_STA]),
        .sto (host_wdata[CTL_STO]),
        .cmd (dec_cmd)
    );

    smb_byte_engine #(.DIV(DIV)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (launch),
        .op_i     (launch_op),
        .tx_byte_i(q.data),
        .ack_en_i (q.acken),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe),
        .busy     (eng_busy),
        .done     (eng_done),
        .rx_byte  (eng_rx),
        .ack_smp  (eng_ack)
    );

    assign busy_any = eng_busy || (q.cmd_pend != CMD_NOP) || q.tx_pend || q.rx_pend;

    always_comb begin
        status           = 8'h00;
        status[STS_PEND] = q.pend;
        status[STS_BUSY] = busy_any;
        status[STS_MST]  = (q.mode != MODE_SRX);
        status[STS_RCV]  = (q.mode == MODE_MRX);
        status[STS_LAK]  = q.lak;
    end

    assign host_rdata = host_sel ? status : q.data;
    assign int_n      = ~(q.ien & ~q.pend);

    always_comb begin
        d         = q;
        launch    = 1'b0;
        launch_op = OP_TX;

        // hand work to the engine when it is free
        if (!eng_busy) begin
            if (q.cmd_pend != CMD_NOP) begin
                launch     = 1'b1;
                d.cmd_pend = CMD_NOP;
                d.tx_pend  = 1'b0;
                d.rx_pend  = 1'b0;
                unique case (q.cmd_pend)
                    CMD_START: begin
                        launch_op = OP_START_TX;
                        d.addr_ph = 1'b1;
                    end
                    CMD_RSTART: begin
                        launch_op = OP_RSTART;
                        d.mode    = MODE_MTX;
                        d.addr_ph = 1'b1;
                    end
                    CMD_CHAIN: begin
                        launch_op = OP_CHAIN;
                        d.mode    = MODE_MTX;
                        d.addr_ph = 1'b1;
                    end
                    default: begin
                        launch_op = OP_STOP;
                        d.mode    = MODE_SRX;
                        d.addr_ph = 1'b0;
                    end
                endcase
            end else if (q.tx_pend && q.mode == MODE_MTX) begin
                launch    = 1'b1;
                launch_op = OP_TX;
                d.tx_pend = 1'b0;
            end else if (q.rx_pend && q.mode == MODE_MRX) begin
                launch    = 1'b1;
                launch_op = OP_RX;
                d.rx_pend = 1'b0;
            end
        end

        // host accesses
        if (host_wr && !host_sel) begin
            d.data = host_wdata;
            if (q.mode == MODE_MTX) begin
                d.pend    = 1'b1;
                d.tx_pend = 1'b1;
            end
        end
        if (host_rd && !host_sel && q.mode == MODE_MRX) begin
            d.pend    = 1'b1;
            d.rx_pend = 1'b1;
        end
        if (host_wr && host_sel) begin
            d.ien   = host_wdata[CTL_IEN];
            d.acken = host_wdata[CTL_ACK];
            if (dec_cmd != CMD_NOP) d.cmd_pend = dec_cmd;
        end

        // byte completion
        if (eng_done) begin
            d.pend = 1'b0;
            if (q.addr_ph) begin
                d.mode    = q.data[0] ? MODE_MRX : MODE_MTX;
                d.addr_ph = 1'b0;
                d.lak     = eng_ack;
            end else if (q.mode == MODE_MTX) begin
                d.lak = eng_ack;
            end else if (q.mode == MODE_MRX) begin
                d.data = eng_rx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= TOP_RST;
        else        q <= d;
    end

    // byte completion always demands service (R8)
    p_done_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> !q.pend);

    // from idle mode only an address start can reach the engine (R6)
    p_srx_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && q.mode == MODE_SRX) |-> (launch_op == OP_START_TX));

    // int_n only asserts with service pending (R10)
    p_int_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n |-> !status[STS_PEND]);

endmodule

// File: tb/sim_smb_master_ctl.sv
`timescale 1ns/1ps
module sim_smb_master_ctl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic int_n, scl_oe, sda_oe;
    logic s_drv = 1'b0;
    wire  scl_w = ~scl_oe;
    wire  sda_w = ~(sda_oe | s_drv);

    int total = 0, bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    smb_master_ctl #(.DIV(4)) u0 (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .int_n(int_n), .scl_in(scl_w), .sda_in(sda_w),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // ---------------- behavioural slave at address 0x2A ----------------
    localparam logic [6:0] SLV = 7'h2A;
    int n_start = 0, n_stop = 0, wn = 0, acks_seen = 0, nacks_seen = 0, rd_n = 0, bc = 0;
    logic [7:0] wlog [0:15];
    logic [7:0] sh = 8'h00, tb = 8'h00;
    logic p_scl = 1'b1, p_sda = 1'b1, matched = 1'b0, rdir = 1'b0, xmit = 1'b0, aph = 1'b0, m_ack = 1'b1;

    always @(negedge clk) begin
        if (p_scl && scl_w && p_sda && !sda_w) begin
            n_start++; bc = 0; xmit = 1'b0; s_drv = 1'b0; aph = 1'b1;
        end else if (p_scl && scl_w && !p_sda && sda_w) begin
            n_stop++; xmit = 1'b0; s_drv = 1'b0; matched = 1'b0;
        end else if (!p_scl && scl_w) begin
            if (bc < 8) sh = {sh[6:0], sda_w};
            else        m_ack = sda_w;
            bc++;
        end else if (p_scl && !scl_w) begin
            if (bc == 8) begin
                if (aph) begin
                    aph = 1'b0; matched = (sh[7:1] == SLV); rdir = sh[0]; s_drv = matched;
                end else if (!xmit && matched) begin
                    wlog[wn[3:0]] = sh; wn++; s_drv = 1'b1;
                end else s_drv = 1'b0;
            end else if (bc == 9) begin
                bc = 0; s_drv = 1'b0;
                if (matched && rdir) begin
                    if (!xmit) begin
                        xmit = 1'b1; tb = 8'hA5 + 8'(rd_n * 17); rd_n++; s_drv = ~tb[7];
                    end else if (!m_ack) begin
                        acks_seen++; tb = 8'hA5 + 8'(rd_n * 17); rd_n++; s_drv = ~tb[7];
                    end else begin
                        nacks_seen++; xmit = 1'b0;
                    end
                end
            end else if (xmit && bc >= 1 && bc <= 7) begin
                s_drv = ~tb[7-bc];
            end
        end
        p_scl = scl_w; p_sda = sda_w;
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic sel, input logic [7:0] v);
        @(negedge clk); host_sel = sel; host_wdata = v; host_wr = 1'b1;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic hread(input logic sel, output logic [7:0] v);
        @(negedge clk); host_sel = sel; host_rd = 1'b1; #1 v = host_rdata;
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic peek_status(output logic [7:0] v);
        @(negedge clk); host_sel = 1'b1; #1 v = host_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 4000; i++) begin
            peek_status(s);
            if (!s[6]) break;
        end
        repeat (2) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [7:0] s;
        peek_status(s);
        chk("R1 R12 reset status", s, 8'h80);
        chk("R1 R10 reset int_n", int_n, 1);
        chk("R1 reset lines", {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_write_stop();
        logic [7:0] s;
        int st0, sp0;
        hwrite(1'b1, 8'h03);
        hwrite(1'b0, 8'h54);
        hwrite(1'b1, 8'h43);
        wait_idle();
        chk("R2 one START", n_start, 1);
        peek_status(s);
        chk("R2 R8 R11 status after address", s, 8'h20);
        chk("R10 int_n low when pending", int_n, 0);
        hwrite(1'b0, 8'h3C);
        peek_status(s);
        chk("R9 pend set by data write", s[7], 1);
        chk("R10 int_n released", int_n, 1);
        wait_idle();
        chk("R9 byte MSB first at slave", wlog[0], 8'h3C);
        peek_status(s);
        chk("R8 pend after data byte", s[7], 0);
        hwrite(1'b1, 8'h02);
        chk("R10 irq disabled", int_n, 1);
        st0 = n_start; sp0 = n_stop;
        repeat (100) @(negedge clk);
        peek_status(s);
        chk("R6 empty command in master", s, 8'h20);
        chk("R6 no condition", n_start + n_stop, st0 + sp0);
        hwrite(1'b1, 8'h22);
        wait_idle();
        chk("R4 STOP seen", n_stop, sp0 + 1);
        peek_status(s);
        chk("R4 back to idle", s, 8'h00);
        chk("R4 lines released", {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_idle_nops();
        logic [7:0] s;
        int st0, sp0;
        st0 = n_start; sp0 = n_stop;
        hwrite(1'b1, 8'h22);
        repeat (200) @(negedge clk);
        hwrite(1'b1, 8'h62);
        repeat (200) @(negedge clk);
        chk("R6 stop/start+stop in idle silent", n_start + n_stop, st0 + sp0);
        peek_status(s);
        chk("R6 idle status unchanged", s, 8'h00);
        chk("R6 lines untouched", {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_read();
        logic [7:0] s, v;
        int a0, n0;
        a0 = acks_seen; n0 = nacks_seen;
        hwrite(1'b0, 8'h55);
        hwrite(1'b1, 8'h42);
        wait_idle();
        peek_status(s);
        chk("R2 master-receive after read address", s, 8'h30);
        hwrite(1'b1, 8'h02);
        hread(1'b0, v);
        peek_status(s);
        chk("R9 pend set by data read", s[7], 1);
        wait_idle();
        hwrite(1'b1, 8'h00);
        hread(1'b0, v);
        chk("R9 first received byte", v, 8'hA5);
        wait_idle();
        chk("R7 ACK driven on first byte", acks_seen, a0 + 1);
        chk("R7 NACK on last byte", nacks_seen, n0 + 1);
        hwrite(1'b1, 8'h20);
        wait_idle();
        hread(1'b0, v);
        chk("R9 second received byte", v, 8'hB6);
        peek_status(s);
        chk("R4 idle after read stop", s[5], 0);
    endtask

    task automatic t_nack_addr();
        logic [7:0] s;
        hwrite(1'b0, 8'h40);
        hwrite(1'b1, 8'h40);
        wait_idle();
        peek_status(s);
        chk("R11 address NACK visible", s, 8'h21);
        hwrite(1'b1, 8'h20);
        wait_idle();
    endtask

    task automatic t_rstart();
        logic [7:0] s, v;
        int st0, sp0;
        hwrite(1'b0, 8'h54);
        hwrite(1'b1, 8'h40);
        wait_idle();
        hwrite(1'b0, 8'h11);
        wait_idle();
        st0 = n_start; sp0 = n_stop;
        hwrite(1'b1, 8'h40);
        wait_idle();
        chk("R3 repeated START", n_start, st0 + 1);
        chk("R3 no STOP before it", n_stop, sp0);
        chk("R3 SCL held low", scl_oe, 1);
        hwrite(1'b0, 8'h55);
        wait_idle();
        peek_status(s);
        chk("R3 mode from new address", s, 8'h30);
        hread(1'b0, v);
        wait_idle();
        hwrite(1'b1, 8'h20);
        wait_idle();
    endtask

    task automatic t_chain();
        logic [7:0] s;
        int st0, sp0, w0;
        hwrite(1'b0, 8'h54);
        hwrite(1'b1, 8'h40);
        wait_idle();
        st0 = n_start; sp0 = n_stop;
        hwrite(1'b1, 8'h60);
        wait_idle();
        chk("R5 STOP in chain", n_stop, sp0 + 1);
        chk("R5 START in chain", n_start, st0 + 1);
        chk("R5 SCL kept low", scl_oe, 1);
        peek_status(s);
        chk("R5 still master", s[5], 1);
        w0 = wn;
        hwrite(1'b0, 8'h54);
        wait_idle();
        hwrite(1'b0, 8'h77);
        wait_idle();
        chk("R5 byte after chain", wlog[w0[3:0]], 8'h77);
        hwrite(1'b1, 8'h20);
        wait_idle();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_write_stop();
        t_idle_nops();
        t_read();
        t_nack_addr();
        t_rstart();
        t_chain();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule